// File: doc/BRIEF.md
# Key-Protected Watchdog Reset Timer

This block is a watchdog counter with a small register port. Its control registers (enable, match value and event status) are guarded by a two-key unlock sequence. Software first writes one key value to a key register and then a second key value to another key register. That pair of writes opens the block for exactly one write to a guarded register, and the block then locks again. Writes that do not follow a fresh key pair are dropped.

When counting is enabled, the counter advances on each cycle in which the function-clock tick input is high. When the count reaches the programmed match value, the block records an event in the status register and returns the counter to zero. If reset generation is also enabled, it drives a system reset pulse of fixed length. The current count can be read at any time without unlocking.

Top module: `wdt_keylock`

## Requirements
- R1: After reset the block is locked, the enable field is 0, the match value is all ones, status is 0, the count is 0 and `sys_rst_o` is low.
- R2: A write of 0xBABA to the first key register (address 4), followed by a write of 0xEB10 to the second key register (address 5) as the next bus access, unlocks the block. A following write to a guarded register (address 0 enable, 1 match, 2 status) takes effect.
- R3: After one guarded write the block is locked again, and a second guarded write made without a new key pair leaves the register unchanged.
- R4: A wrong key value, the keys in the wrong order, or any other bus access (read or write) between the two key writes returns the block to the locked state, and the guarded write that follows is ignored.
- R5: A guarded-register write made while locked is ignored.
- R6: With enable bit 0 set, the count increases by one for each cycle with `tick_i` high and holds while `tick_i` is low. Clearing enable bit 0 clears the count to 0. The count reads at address 3 without unlocking.
- R7: On the tick that would bring the count to the match value, status bit 0 is set and the count returns to 0.
- R8: If enable bit 1 is also set at the match, `sys_rst_o` goes high in the next cycle and stays high for exactly 16 cycles.
- R9: With only enable bit 0 set, a match sets status but `sys_rst_o` stays low.
- R10: An unlocked write of 0 to the status register (address 2) clears the event. The same write made while locked leaves status set.
- R11: Reads return the enable field in bits [1:0] at address 0, the match value at address 1, the status in bit 0 at address 2, the count at address 3, and 0 at the key addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Bus access strobe, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` (combinational) |
| tick_i | input | 1 | Function-clock tick enable for the counter |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The bench targets the ways the lock can be bypassed: a wrong key, the keys in swapped order, and a read placed between the keys. A sequencer that ignored any of these would let the following match write through. It also checks that one key pair does not unlock twice, which a sticky unlock would fail. On the counter side it checks the exact tick at which the match fires, that the count returns to zero, and that a reset pulse is 16 cycles long only when reset generation is enabled. An off-by-one compare, a pulse in status-only mode, or a wrong pulse length would each give a different read value or pulse count. Status clearing is checked both locked and unlocked.

// File: rtl/wdt_keylock_pkg.sv
package wdt_keylock_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd0;
  localparam logic [ADDR_W-1:0] A_MATCH  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_KEY1   = 3'd4;
  localparam logic [ADDR_W-1:0] A_KEY2   = 3'd5;

  localparam logic [15:0] KEY1_VAL = 16'hBABA;
  localparam logic [15:0] KEY2_VAL = 16'hEB10;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

  function automatic logic is_guarded(input logic [ADDR_W-1:0] a);
    return (a == A_ENABLE) || (a == A_MATCH) || (a == A_STATUS);
  endfunction
endpackage

// File: rtl/wdt_unlock_fsm.sv
module wdt_unlock_fsm
  import wdt_keylock_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              grant_o
);
  lock_state_e state_q, state_d;
  logic key1_hit, key2_hit;

  assign key1_hit = acc_i && wr_i && (addr_i == A_KEY1) && (wdata_i == DATA_W'(KEY1_VAL));
  assign key2_hit = acc_i && wr_i && (addr_i == A_KEY2) && (wdata_i == DATA_W'(KEY2_VAL));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LK_LOCKED: if (key1_hit) state_d = LK_HALF;
      LK_HALF:   if (acc_i) state_d = key2_hit ? LK_OPEN : LK_LOCKED;
      LK_OPEN:   if (acc_i) state_d = LK_LOCKED;
      default:   state_d = LK_LOCKED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= LK_LOCKED;
    else         state_q <= state_d;

  assign grant_o = (state_q == LK_OPEN) && acc_i && wr_i && is_guarded(addr_i);

  assert_open_from_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LK_OPEN && $past(state_q) != LK_OPEN) |-> $past(state_q) == LK_HALF);

  assert_single_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> state_q == LK_LOCKED);

  assert_break_relocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LK_HALF && acc_i && !key2_hit) |=> state_q == LK_LOCKED);
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_en_i,
  input  logic             rst_en_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             st_wr_i,
  input  logic             st_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             status_o,
  output logic             sys_rst_o
);
  localparam int PW = $clog2(RST_LEN + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(RST_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [PW-1:0]    pulse_q;
  logic             status_q, fire;

  assign cnt_nxt = cnt_q + 1'b1;
  assign fire    = cnt_en_i && tick_i && (cnt_nxt == match_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        cnt_q <= '0;
    else if (!cnt_en_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= fire ? '0 : cnt_nxt;

  // a new event wins over a same-cycle status write
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      status_q <= 1'b0;
    else if (fire)    status_q <= 1'b1;
    else if (st_wr_i) status_q <= st_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                pulse_q <= '0;
    else if (fire && rst_en_i)  pulse_q <= PULSE_LOAD;
    else if (pulse_q != '0)     pulse_q <= pulse_q - 1'b1;

  assign count_o   = cnt_q;
  assign status_o  = status_q;
  assign sys_rst_o = (pulse_q != '0);

  // pulse-length checker
  logic [PW:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               hi_len_q <= '0;
    else if (fire && rst_en_i) hi_len_q <= sys_rst_o ? '0 : hi_len_q;
    else if (sys_rst_o)        hi_len_q <= hi_len_q + 1'b1;
    else                       hi_len_q <= '0;

  assert_pulse_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> hi_len_q == (PW+1)'(RST_LEN));

  assert_rst_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(rst_en_i));

  assert_rst_sets_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> status_q);

  assert_count_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> cnt_q == '0);
endmodule

// File: rtl/wdt_keylock.sv
module wdt_keylock
  import wdt_keylock_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RST_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              tick_i,
  output logic              sys_rst_o
);
  logic              grant;
  logic [1:0]        en_q;
  logic [DATA_W-1:0] match_q;
  logic [DATA_W-1:0] count;
  logic              status;

  wdt_unlock_fsm #(.DATA_W(DATA_W)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (bus_valid_i),
    .wr_i    (bus_write_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .grant_o (grant)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_q    <= '0;
      match_q <= '1;
    end else if (grant) begin
      if (bus_addr_i == A_ENABLE) en_q    <= bus_wdata_i[1:0];
      if (bus_addr_i == A_MATCH)  match_q <= bus_wdata_i;
    end

  wdt_count_core #(.CNT_W(DATA_W), .RST_LEN(RST_LEN)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cnt_en_i   (en_q[0]),
    .rst_en_i   (en_q[1]),
    .match_i    (match_q),
    .st_wr_i    (grant && bus_addr_i == A_STATUS),
    .st_wdata_i (bus_wdata_i[0]),
    .count_o    (count),
    .status_o   (status),
    .sys_rst_o  (sys_rst_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_ENABLE: bus_rdata_o = DATA_W'(en_q);
      A_MATCH:  bus_rdata_o = match_q;
      A_STATUS: bus_rdata_o = DATA_W'(status);
      A_COUNT:  bus_rdata_o = count;
      default:  bus_rdata_o = '0;
    endcase
  end

  assert_match_guarded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(match_q) |-> $past(grant && bus_addr_i == A_MATCH));

  assert_enable_guarded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q) |-> $past(grant && bus_addr_i == A_ENABLE));
endmodule

// File: tb/wdt_keylock_tb_top.sv
module wdt_keylock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0, tick = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sys_rst;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  wdt_keylock dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tick_i(tick), .sys_rst_o(sys_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; write = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); valid = 1; write = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); valid = 0;
  endtask

  task automatic unlock();
    wr(3'd4, 16'hBABA);
    wr(3'd5, 16'hEB10);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 sys_rst", sys_rst, 0);
    rd(3'd0, v); chk("R1 enable", v, 0);
    rd(3'd1, v); chk("R1 match", v, 16'hFFFF);
    rd(3'd2, v); chk("R1 status", v, 0);
    rd(3'd3, v); chk("R1 count", v, 0);
    rd(3'd4, v); chk("R11 key1 reads 0", v, 0);
    rd(3'd5, v); chk("R11 key2 reads 0", v, 0);
  endtask

  task automatic t_locked_write();
    logic [15:0] v;
    wr(3'd1, 16'h0010);
    rd(3'd1, v); chk("R5 locked match write", v, 16'hFFFF);
  endtask

  task automatic t_unlock_once();
    logic [15:0] v;
    unlock(); wr(3'd1, 16'h0020);
    rd(3'd1, v); chk("R2 unlocked write", v, 16'h0020);
    unlock(); wr(3'd1, 16'h0021); wr(3'd1, 16'h0030);
    rd(3'd1, v); chk("R3 second write ignored", v, 16'h0021);
  endtask

  task automatic t_bad_keys();
    logic [15:0] v;
    wr(3'd4, 16'hBABB); wr(3'd5, 16'hEB10); wr(3'd1, 16'h0040);
    rd(3'd1, v); chk("R4 wrong key1", v, 16'h0021);
    wr(3'd4, 16'hBABA); wr(3'd5, 16'hEB11); wr(3'd1, 16'h0041);
    rd(3'd1, v); chk("R4 wrong key2", v, 16'h0021);
    wr(3'd5, 16'hEB10); wr(3'd4, 16'hBABA); wr(3'd1, 16'h0042);
    rd(3'd1, v); chk("R4 swapped order", v, 16'h0021);
    wr(3'd4, 16'hBABA); rd(3'd3, v); wr(3'd5, 16'hEB10); wr(3'd1, 16'h0043);
    rd(3'd1, v); chk("R4 read between keys", v, 16'h0021);
  endtask

  task automatic t_count();
    logic [15:0] v;
    unlock(); wr(3'd0, 16'h0001);
    ticks(7);
    rd(3'd3, v); chk("R6 count after 7 ticks", v, 7);
    repeat (5) @(negedge clk);
    rd(3'd3, v); chk("R6 count holds without tick", v, 7);
    unlock(); wr(3'd0, 16'h0000);
    rd(3'd3, v); chk("R6 disable clears count", v, 0);
  endtask

  task automatic t_match_status();
    logic [15:0] v;
    int hi = 0;
    unlock(); wr(3'd1, 16'h0005);
    unlock(); wr(3'd0, 16'h0001);
    ticks(4);
    rd(3'd3, v); chk("R7 count before match", v, 4);
    rd(3'd2, v); chk("R7 status before match", v, 0);
    ticks(1);
    for (int i = 0; i < 20; i++) begin
      if (sys_rst) hi++;
      @(negedge clk);
    end
    chk("R9 no reset in status-only mode", hi, 0);
    rd(3'd3, v); chk("R7 count wraps to 0", v, 0);
    rd(3'd2, v); chk("R7 status set", v, 1);
    rd(3'd0, v); chk("R11 enable readback", v, 1);
  endtask

  task automatic t_status_clear();
    logic [15:0] v;
    wr(3'd2, 16'h0000);
    rd(3'd2, v); chk("R10 locked clear ignored", v, 1);
    unlock(); wr(3'd2, 16'h0000);
    rd(3'd2, v); chk("R10 unlocked clear", v, 0);
  endtask

  task automatic t_reset_pulse();
    logic [15:0] v;
    int n = 0;
    unlock(); wr(3'd0, 16'h0000);
    unlock(); wr(3'd0, 16'h0003);
    rd(3'd0, v); chk("R11 enable reads 3", v, 3);
    ticks(4);
    chk("R8 no reset before match", sys_rst, 0);
    ticks(1);
    while (sys_rst && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R8 reset pulse length", n, 16);
    rd(3'd2, v); chk("R7 status after reset event", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_locked_write();
    t_unlock_once();
    t_bad_keys();
    t_count();
    t_match_status();
    t_status_clear();
    t_reset_pulse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule